// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit sits beside the transmit and receive byte FIFOs of a serial peripheral controller. It counts how many bytes each FIFO holds from the push and pop strobes that the FIFO clients raise. It presents the two counts, two live level flags and two latched threshold events in one status word. A mask register chooses which of the four status bits drive a single interrupt line.

On the receive side the shift engine pushes one byte per strobe. Software drains either a whole 32-bit word or single bytes, so a pop removes 0 to 4 bytes. On the transmit side software writes up to 4 bytes per strobe and the shift engine removes one byte per strobe. Both counts saturate at 0 and at the FIFO depth.

A small register port selects one of three targets: the mode word with the two fill thresholds, the status word (write ones to clear), or the mask. A receive threshold event latches when the receive count is above its threshold. A transmit threshold event latches when the transmit count is below its threshold. Software uses these to take an interrupt only once enough data has piled up, or enough space has opened.

Top module: `spi_fifo_evt_irq`

## Requirements
- R1: While reset is held, the status word reads 0x00000100 and irq is 0. On release the receive threshold is 3, the transmit threshold is 4 and the mask is 0.
- R2: The receive count in status bits 29:24 rises by 1 on rx_push and falls by rx_pop_n (0 to 4). The result is clamped to the range 0 to 32.
- R3: The transmit count in status bits 21:16 rises by tx_push_n (0 to 4) and falls by 1 on tx_pop. The result is clamped to the range 0 to 32.
- R4: A push and a pop on the same FIFO in the same cycle apply their net difference to the count.
- R5: Status bit 9 is 1 exactly when the receive count is nonzero. Status bit 8 is 1 exactly when the transmit count is below 32. Both bits follow the counts with no latching, and writes do not affect them.
- R6: A write with reg_sel=0 loads the receive threshold from reg_wdata[5:0] and the transmit threshold from reg_wdata[13:8].
- R7: Status bit 1 latches one cycle after the receive count exceeds the receive threshold. Status bit 0 latches one cycle after the transmit count falls below the transmit threshold. Both stay set until cleared.
- R8: A write with reg_sel=1 clears status bit 1 or 0 wherever reg_wdata has a 1 in that position. A 0 in reg_wdata leaves the bit as it is.
- R9: If a clear write and a set condition hit the same latched bit in the same cycle, the bit stays set.
- R10: A write with reg_sel=2 loads the mask from reg_wdata bits 9, 8, 1 and 0. irq is the OR of those four status bits, each ANDed with its mask bit, so a zero mask keeps irq at 0.
- R11: Status bits 31:30, 23:22, 15:10 and 7:2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| rx_push | input | 1 | Shift engine wrote one byte into the receive FIFO |
| rx_pop_n | input | 3 | Bytes software removed from the receive FIFO this cycle (0 to 4) |
| tx_push_n | input | 3 | Bytes software wrote into the transmit FIFO this cycle (0 to 4) |
| tx_pop | input | 1 | Shift engine took one byte from the transmit FIFO |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 mode, 1 status clear, 2 mask, 3 none |
| reg_wdata | input | 32 | Register write data |
| event_word | output | 32 | Status word: counts, level flags, latched threshold events |
| irq | output | 1 | Masked interrupt request |

## Verification
Two kinds of event can fall in the same cycle: a threshold event being set, and a software write that clears the same latched bit. The bench provokes this with the transmit threshold above the current count, issuing the clearing write while the condition still holds, and judges that the bit is still set one cycle later. The bench also pairs pushes with pops on the same FIFO in one cycle and checks that the count moves by the net amount. Random traffic near empty and near full exercises both clamps.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
  localparam int unsigned FLD_W      = 6;
  localparam int unsigned RXCNT_LSB  = 24;
  localparam int unsigned TXCNT_LSB  = 16;
  localparam int unsigned BIT_RXNE   = 9;
  localparam int unsigned BIT_TXNF   = 8;
  localparam int unsigned BIT_RXTHR  = 1;
  localparam int unsigned BIT_TXTHR  = 0;
  localparam int unsigned THR_RX_LSB = 0;
  localparam int unsigned THR_TX_LSB = 8;
  localparam int unsigned THR_RX_INIT = 3;
  localparam int unsigned THR_TX_INIT = 4;
  localparam int unsigned N_STICKY   = 2;
  localparam int unsigned N_IRQSRC   = 4;

  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_EVENT = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/spi_evt_level.sv
module spi_evt_level #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned STEP_W = 3,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] add_n,
  input  logic [STEP_W-1:0] sub_n,
  output logic [CW-1:0]     level
);
  localparam int unsigned SW = CW + 2;

  logic [CW-1:0] level_q, level_d;
  logic [SW-1:0] sum, diff;
  logic          upd_en;

  always_comb begin
    sum    = SW'(level_q) + SW'(add_n);
    diff   = sum - SW'(sub_n);
    upd_en = (|add_n) || (|sub_n);
    if (sum < SW'(sub_n))
      level_d = '0;
    else if (diff > SW'(DEPTH))
      level_d = CW'(DEPTH);
    else
      level_d = CW'(diff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      level_q <= '0;
    else if (upd_en)
      level_q <= level_d;
  end

  assign level = level_q;
endmodule

// File: rtl/spi_evt_regs.sv
module spi_evt_regs
  import spi_evt_pkg::*;
#(
  parameter int unsigned THR_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  reg_sel_e              sel,
  input  logic [31:0]           wdata,
  output logic [THR_W-1:0]      rx_thr,
  output logic [THR_W-1:0]      tx_thr,
  output logic [N_IRQSRC-1:0]   mask,
  output logic [N_STICKY-1:0]   clr
);
  logic [THR_W-1:0]    rx_thr_q, tx_thr_q;
  logic [N_IRQSRC-1:0] mask_q;
  logic                mode_en, mask_en;

  always_comb begin
    mode_en = wr && (sel == SEL_MODE);
    mask_en = wr && (sel == SEL_MASK);
    clr     = '0;
    if (wr && (sel == SEL_EVENT)) begin
      clr[1] = wdata[BIT_RXTHR];
      clr[0] = wdata[BIT_TXTHR];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_thr_q <= THR_W'(THR_RX_INIT);
      tx_thr_q <= THR_W'(THR_TX_INIT);
    end else if (mode_en) begin
      rx_thr_q <= wdata[THR_RX_LSB +: THR_W];
      tx_thr_q <= wdata[THR_TX_LSB +: THR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '0;
    else if (mask_en)
      mask_q <= {wdata[BIT_RXNE], wdata[BIT_TXNF], wdata[BIT_RXTHR], wdata[BIT_TXTHR]};
  end

  assign rx_thr = rx_thr_q;
  assign tx_thr = tx_thr_q;
  assign mask   = mask_q;
endmodule

// File: rtl/spi_evt_sticky.sv
module spi_evt_sticky #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q_q, q_d, en;
    always_comb begin
      en  = set[i] | clr[i];
      q_d = set[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q_q <= 1'b0;
      else if (en)
        q_q <= q_d;
    end
    assign q[i] = q_q;
  end
endmodule

// File: rtl/spi_fifo_evt_irq.sv
module spi_fifo_evt_irq
  import spi_evt_pkg::*;
#(
  parameter int unsigned DEPTH      = 32,
  parameter int unsigned PORT_BYTES = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               rx_push,
  input  logic [$clog2(PORT_BYTES+1)-1:0]    rx_pop_n,
  input  logic [$clog2(PORT_BYTES+1)-1:0]    tx_push_n,
  input  logic                               tx_pop,
  input  logic                               reg_wr,
  input  logic [1:0]                         reg_sel,
  input  logic [31:0]                        reg_wdata,
  output logic [31:0]                        event_word,
  output logic                               irq
);
  localparam int unsigned CW     = $clog2(DEPTH + 1);
  localparam int unsigned STEP_W = $clog2(PORT_BYTES + 1);

  logic [1:0]          rst_pipe;
  logic                rst_sync_n;
  logic [CW-1:0]       rx_lvl, tx_lvl, rx_thr, tx_thr;
  logic [N_IRQSRC-1:0] mask, src;
  logic [N_STICKY-1:0] ev_set, ev_clr, ev_q;
  logic [STEP_W-1:0]   rx_add, tx_sub;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= '0;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign rx_add = STEP_W'(rx_push);
  assign tx_sub = STEP_W'(tx_pop);

  spi_evt_level #(.DEPTH(DEPTH), .STEP_W(STEP_W)) u_rx_level (
    .clk(clk), .rst_n(rst_sync_n), .add_n(rx_add), .sub_n(rx_pop_n), .level(rx_lvl)
  );

  spi_evt_level #(.DEPTH(DEPTH), .STEP_W(STEP_W)) u_tx_level (
    .clk(clk), .rst_n(rst_sync_n), .add_n(tx_push_n), .sub_n(tx_sub), .level(tx_lvl)
  );

  spi_evt_regs #(.THR_W(CW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr(reg_wr), .sel(reg_sel_e'(reg_sel)),
    .wdata(reg_wdata), .rx_thr(rx_thr), .tx_thr(tx_thr), .mask(mask), .clr(ev_clr)
  );

  always_comb begin
    ev_set[1] = rx_lvl > rx_thr;
    ev_set[0] = tx_lvl < tx_thr;
  end

  spi_evt_sticky #(.N(N_STICKY)) u_sticky (
    .clk(clk), .rst_n(rst_sync_n), .set(ev_set), .clr(ev_clr), .q(ev_q)
  );

  always_comb begin
    event_word = '0;
    event_word[RXCNT_LSB +: FLD_W] = FLD_W'(rx_lvl);
    event_word[TXCNT_LSB +: FLD_W] = FLD_W'(tx_lvl);
    event_word[BIT_RXNE]  = rx_lvl != '0;
    event_word[BIT_TXNF]  = tx_lvl < CW'(DEPTH);
    event_word[BIT_RXTHR] = ev_q[1];
    event_word[BIT_TXTHR] = ev_q[0];
    src = {event_word[BIT_RXNE], event_word[BIT_TXNF],
           event_word[BIT_RXTHR], event_word[BIT_TXTHR]};
    irq = |(src & mask);
  end
endmodule

// File: rtl/spi_fifo_evt_irq_chk.sv
module spi_fifo_evt_irq_chk #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CW    = 6,
  parameter int unsigned SW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_push,
  input logic [SW-1:0] rx_pop_n,
  input logic [CW-1:0] rx_lvl,
  input logic [CW-1:0] tx_lvl,
  input logic [CW-1:0] rx_thr,
  input logic [CW-1:0] tx_thr,
  input logic [3:0]    mask,
  input logic          reg_wr,
  input logic [1:0]    reg_sel,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   event_word,
  input logic          irq
);
  p_rx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lvl <= CW'(DEPTH));

  p_tx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lvl <= CW'(DEPTH));

  p_rx_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_pop_n == '0 && rx_lvl < CW'(DEPTH)) |=> (rx_lvl == $past(rx_lvl) + 1'b1));

  p_rx_net_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_pop_n == SW'(1)) |=> $stable(rx_lvl));

  p_rxne_r5: assert property (@(posedge clk) disable iff (!rst_n)
    event_word[9] == (event_word[29:24] != 6'd0));

  p_txnf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    event_word[8] == (event_word[21:16] != 6'(DEPTH)));

  p_rxthr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_lvl > rx_thr) |=> event_word[1]);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd1 && reg_wdata[1] && !(rx_lvl > rx_thr)) |=> !event_word[1]);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd1 && reg_wdata[0] && (tx_lvl < tx_thr)) |=> event_word[0]);

  p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 4'd0) |-> !irq);

  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (event_word & 32'hC0C0_FCFC) == 32'd0);
endmodule

bind spi_fifo_evt_irq spi_fifo_evt_irq_chk #(
  .DEPTH(DEPTH), .CW(CW), .SW(STEP_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .rx_push(rx_push), .rx_pop_n(rx_pop_n),
  .rx_lvl(rx_lvl), .tx_lvl(tx_lvl), .rx_thr(rx_thr), .tx_thr(tx_thr),
  .mask(mask), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .event_word(event_word), .irq(irq)
);

// File: tb/spi_fifo_evt_irq_bench.sv
module spi_fifo_evt_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_push, tx_pop, reg_wr;
  logic [2:0]  rx_pop_n, tx_push_n;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata, event_word;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int m_rx, m_tx, m_rthr, m_tthr;
  bit m_evr, m_evt;
  bit [3:0] m_mask;

  always #10 clk = ~clk;

  spi_fifo_evt_irq u_spi_fifo_evt_irq (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop_n(rx_pop_n),
    .tx_push_n(tx_push_n), .tx_pop(tx_pop), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .event_word(event_word), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int clamp32(int v);
    if (v < 0) return 0;
    if (v > 32) return 32;
    return v;
  endfunction

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    w[29:24] = 6'(m_rx);
    w[21:16] = 6'(m_tx);
    w[9] = (m_rx != 0);
    w[8] = (m_tx < 32);
    w[1] = m_evr;
    w[0] = m_evt;
    return w;
  endfunction

  function automatic logic exp_irq();
    logic [31:0] w = exp_word();
    return |({w[9], w[8], w[1], w[0]} & m_mask);
  endfunction

  task automatic step(logic rp, logic [2:0] rpop, logic [2:0] tpush, logic tp,
                      logic wr, logic [1:0] sel, logic [31:0] wd);
    int nrx, ntx, nrthr, ntthr;
    bit nevr, nevt;
    bit [3:0] nmask;
    logic [31:0] w;
    @(negedge clk);
    rx_push = rp; rx_pop_n = rpop; tx_push_n = tpush; tx_pop = tp;
    reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    nrx = clamp32(m_rx + int'(rp) - int'(rpop));
    ntx = clamp32(m_tx + int'(tpush) - int'(tp));
    nevr = (m_rx > m_rthr) ? 1'b1 : ((wr && sel == 2'd1 && wd[1]) ? 1'b0 : m_evr);
    nevt = (m_tx < m_tthr) ? 1'b1 : ((wr && sel == 2'd1 && wd[0]) ? 1'b0 : m_evt);
    nrthr = (wr && sel == 2'd0) ? int'(wd[5:0])  : m_rthr;
    ntthr = (wr && sel == 2'd0) ? int'(wd[13:8]) : m_tthr;
    nmask = (wr && sel == 2'd2) ? {wd[9], wd[8], wd[1], wd[0]} : m_mask;
    @(posedge clk);
    #1;
    m_rx = nrx; m_tx = ntx; m_evr = nevr; m_evt = nevt;
    m_rthr = nrthr; m_tthr = ntthr; m_mask = nmask;
    w = exp_word();
    chk("R2 rx count",   32'(event_word[29:24]), 32'(w[29:24]));
    chk("R3 tx count",   32'(event_word[21:16]), 32'(w[21:16]));
    chk("R5 level flags", 32'(event_word[9:8]),  32'(w[9:8]));
    chk("R7 latched",    32'(event_word[1:0]),   32'(w[1:0]));
    chk("R11 reserved",  event_word & 32'hC0C0_FCFC, 32'd0);
    chk("R10 irq",       32'(irq),               32'(exp_irq()));
  endtask

  task automatic idle();
    step(1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 2'd3, 32'd0);
  endtask

  task automatic rand_phase(int n, int bias);
    for (int i = 0; i < n; i++) begin
      logic rp, tp, wr;
      logic [2:0] rpop, tpush;
      logic [1:0] sel;
      logic [31:0] wd;
      rp    = 1'($urandom_range(1, 0));
      tp    = 1'($urandom_range(1, 0));
      rpop  = ($urandom_range(3, 0) < 3 - bias) ? 3'($urandom_range(4, 0)) : 3'd0;
      tpush = ($urandom_range(3, 0) < bias + 1) ? 3'($urandom_range(4, 0)) : 3'd0;
      wr    = ($urandom_range(15, 0) == 0);
      sel   = 2'($urandom_range(3, 0));
      wd    = $urandom;
      step(rp, rpop, tpush, tp, wr, sel, wd);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    rx_push = 0; rx_pop_n = 0; tx_push_n = 0; tx_pop = 0;
    reg_wr = 0; reg_sel = 2'd3; reg_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset word", event_word, 32'h0000_0100);
    chk("R1 reset irq", 32'(irq), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_rx = 0; m_tx = 0; m_rthr = 3; m_tthr = 4; m_mask = 4'd0;
    m_evr = 1'b0;
    m_evt = 1'b1;  // R7: empty transmit count 0 is below default threshold 4
    chk("R1 tx event after release", 32'(event_word[0]), 32'd1);
    chk("R1 rx event after release", 32'(event_word[1]), 32'd0);

    // R10: enable every source, then phases biased toward fill and drain
    step(1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 2'd2, 32'h0000_0303);
    rand_phase(500, 3);
    rand_phase(500, 0);
    rand_phase(500, 1);

    // R3/R5: fill transmit FIFO past its depth
    for (int i = 0; i < 10; i++) step(1'b0, 3'd0, 3'd4, 1'b0, 1'b0, 2'd3, 32'd0);
    chk("R3 tx clamp at 32", 32'(event_word[21:16]), 32'd32);
    chk("R5 not-full drops", 32'(event_word[8]), 32'd0);

    // R2: empty rx, push two bytes, pop a word
    for (int i = 0; i < 10; i++) step(1'b0, 3'd4, 3'd0, 1'b0, 1'b0, 2'd3, 32'd0);
    step(1'b1, 3'd0, 3'd0, 1'b0, 1'b0, 2'd3, 32'd0);
    step(1'b1, 3'd0, 3'd0, 1'b0, 1'b0, 2'd3, 32'd0);
    step(1'b0, 3'd4, 3'd0, 1'b0, 1'b0, 2'd3, 32'd0);
    chk("R2 rx floor at 0", 32'(event_word[29:24]), 32'd0);
    chk("R5 rx not-empty clear", 32'(event_word[9]), 32'd0);

    // R4: simultaneous push and pop on both FIFOs
    step(1'b1, 3'd0, 3'd0, 1'b0, 1'b0, 2'd3, 32'd0);
    step(1'b1, 3'd1, 3'd1, 1'b1, 1'b0, 2'd3, 32'd0);
    chk("R4 rx net zero", 32'(event_word[29:24]), 32'd1);
    chk("R4 tx net zero", 32'(event_word[21:16]), 32'd32);

    // R8: thresholds that never fire, then clear both latched bits
    step(1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 2'd0, {18'd0, 6'd0, 2'd0, 6'd40});
    idle();
    step(1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 2'd1, 32'hFFFF_FFFF);
    chk("R8 rx event cleared", 32'(event_word[1]), 32'd0);
    chk("R8 tx event cleared", 32'(event_word[0]), 32'd0);
    chk("R5 write leaves flags", 32'(event_word[9:8]), 32'b10);

    // R6: rx threshold 0 with one byte, tx threshold 40 with full FIFO
    step(1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 2'd0, {18'd0, 6'd40, 2'd0, 6'd0});
    idle();
    chk("R6 rx threshold applied", 32'(event_word[1]), 32'd1);
    chk("R6 tx threshold applied", 32'(event_word[0]), 32'd1);

    // R9: clear while condition still holds
    step(1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 2'd1, 32'h0000_0003);
    chk("R9 set beats clear rx", 32'(event_word[1]), 32'd1);
    chk("R9 set beats clear tx", 32'(event_word[0]), 32'd1);

    // R10: zero mask silences, single source enables
    step(1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 2'd2, 32'd0);
    chk("R10 mask zero", 32'(irq), 32'd0);
    step(1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 2'd2, 32'h0000_0200);
    chk("R10 rx not-empty irq", 32'(irq), 32'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule